// File: doc/BRIEF.md
# Event Timestamp Recorder

This block takes a snapshot of the running calendar time whenever a watched event occurs. It keeps the four most recent snapshots. Four event sources are watched: a transition on a digital input pin with selectable direction, a supply changeover from battery to main, a changeover from main to battery, and a low-battery indication. A global enable and one enable per source decide which events are recorded.

Each snapshot holds seven time fields and a flags field. The fields are the 1/128-second count, seconds, minutes, hours, date, month and year. The flags field names the source or sources that caused the capture. The newest snapshot always sits in slot 0, and older ones move one slot deeper on every capture. A mode bit chooses what happens once all four slots are occupied: either the oldest snapshot is dropped, or recording stops. A clear strobe empties every slot, and recording then starts again from slot 0.

A synchronous read port returns any slot in one packed word. The supply and battery comparators sit outside the block and deliver synchronised single-cycle pulses.

Top module: `evt_stamp_rec`

## Requirements
- R1: A recorded event stores the time fields present on the clock edge where the event is seen into slot 0. In the same edge, slot k moves to slot k+1.
- R2: With `ovw_mode`=1, a capture made while all four slots are occupied discards the old slot 3. Slot 3 then holds the oldest surviving snapshot.
- R3: With `ovw_mode`=0 and slot 3 occupied, further events change no slot. A slot counts as occupied when its flags field is non-zero.
- R4: Nothing is recorded while `func_en`=0. The enable bits are `rec_en[0]` for the pin transition, `rec_en[1]` for both supply changeovers and `rec_en[2]` for low battery. An event whose enable bit is clear records nothing.
- R5: A pin event is a change of `din` between two consecutive clock edges. With `din_rise`=1 only a low-to-high change counts. With `din_rise`=0 only a high-to-low change counts. No pin event is seen on the first edge after reset.
- R6: The flags byte sits at `rd_stamp[63:56]`. Bit 0 means pin transition, bit 1 battery-to-main, bit 2 main-to-battery and bit 3 low battery, and bits 7:4 are zero. Events on the same edge produce one snapshot with all their bits set.
- R7: `bank_clr` zeroes every field of every slot, and the next event lands in slot 0. An event on the same edge as `bank_clr` is dropped.
- R8: `rd_stamp` = {flags, year, month, date, hour, minute, second, 1/128-second}, with the 1/128-second field in bits 7:0 and each field 8 bits wide. It shows slot `rd_bank` one edge after `rd_bank` is sampled. After reset, every slot and `rd_stamp` read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tm_frac | input | 8 | Live 1/128-second field |
| tm_sec | input | 8 | Live seconds field |
| tm_min | input | 8 | Live minutes field |
| tm_hour | input | 8 | Live hours field |
| tm_date | input | 8 | Live date field |
| tm_month | input | 8 | Live month field |
| tm_year | input | 8 | Live year field |
| din | input | 1 | Synchronised digital input level |
| din_rise | input | 1 | Pin edge select: 1 rising, 0 falling |
| ev_main | input | 1 | Pulse: supply moved from battery to main |
| ev_batt | input | 1 | Pulse: supply moved from main to battery |
| ev_vlow | input | 1 | Pulse: low battery detected |
| func_en | input | 1 | Global recording enable |
| rec_en | input | 3 | Per-source enables (see R4) |
| ovw_mode | input | 1 | 1 drop oldest when full, 0 stop when full |
| bank_clr | input | 1 | Strobe: clear all slots |
| rd_bank | input | 2 | Slot to read |
| rd_stamp | output | 64 | Registered snapshot of the selected slot |

## Verification
A capture is written on the edge that samples the event. The read port adds one more register, so a snapshot shows on `rd_stamp` two edges after its event was driven. The bench drives every input just after a falling edge and gives each event one full cycle. It then puts the slot number on `rd_bank` and samples `rd_stamp` at the next falling edge, which lands exactly on that two-edge latency. Clears and ignored events are checked the same way, by reading back every slot after the stimulus and before the next one. A sweep over all 128 combinations of source mask and enable mask compares slot 0 after each event.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  localparam int N_TFLD   = 7;
  localparam int FLG_W    = 4;
  localparam int FLG_DIN  = 0;
  localparam int FLG_MAIN = 1;
  localparam int FLG_BATT = 2;
  localparam int FLG_VLOW = 3;
  localparam int EN_DIN   = 0;
  localparam int EN_SUP   = 1;
  localparam int EN_VLOW  = 2;
  localparam int EN_W     = 3;
endpackage

// File: rtl/evt_trig_detect.sv
module evt_trig_detect
  import evt_stamp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             din_rise,
  input  logic             ev_main,
  input  logic             ev_batt,
  input  logic             ev_vlow,
  input  logic             func_en,
  input  logic [EN_W-1:0]  rec_en,
  output logic [FLG_W-1:0] flg
);
  logic din_q;
  logic primed;
  logic din_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q  <= 1'b0;
      primed <= 1'b0;
    end else begin
      din_q  <= din;
      primed <= 1'b1;
    end
  end

  always_comb begin
    if (din_rise) din_ev = primed & din & ~din_q;
    else          din_ev = primed & ~din & din_q;
    flg           = '0;
    flg[FLG_DIN]  = func_en & rec_en[EN_DIN]  & din_ev;
    flg[FLG_MAIN] = func_en & rec_en[EN_SUP]  & ev_main;
    flg[FLG_BATT] = func_en & rec_en[EN_SUP]  & ev_batt;
    flg[FLG_VLOW] = func_en & rec_en[EN_VLOW] & ev_vlow;
  end

  AST_DIN_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    flg[FLG_DIN] |-> (din != din_q)); // R5
endmodule

// File: rtl/evt_stamp_bank.sv
module evt_stamp_bank #(
  parameter int NBANK  = 4,
  parameter int FLD_W  = 8,
  parameter int FLG_W  = 4,
  parameter int N_TFLD = 7,
  localparam int TIME_W = N_TFLD * FLD_W,
  localparam int ENT_W  = TIME_W + FLD_W,
  localparam int SEL_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ovw,
  input  logic [FLG_W-1:0]  cap_flg,
  input  logic [TIME_W-1:0] cap_time,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ENT_W-1:0]  rd_q
);
  logic [NBANK-1:0][ENT_W-1:0] ent;
  logic [NBANK-1:0]            valid;
  logic                        full;
  logic                        wr_en;
  logic [ENT_W-1:0]            new_ent;

  assign new_ent = {{(FLD_W-FLG_W){1'b0}}, cap_flg, cap_time};
  assign full    = valid[NBANK-1];
  assign wr_en   = (|cap_flg) && (ovw || !full);

  for (genvar i = 0; i < NBANK; i++) begin : g_slot
    assign valid[i] = |ent[i][ENT_W-1 -: FLD_W];
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        ent[i] <= '0;
      end else if (wr_en) begin
        if (i == 0) ent[i] <= new_ent;
        else        ent[i] <= ent[(i == 0) ? 0 : i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= ent[rd_sel];
  end

  AST_NEW_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> valid[0]); // R1
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> (ent[1] == $past(ent[0]))); // R2
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ovw && full && !clr) |=> $stable(ent)); // R3
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    clr |=> (valid == '0)); // R7
endmodule

// File: rtl/evt_stamp_rec.sv
module evt_stamp_rec
  import evt_stamp_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int FLD_W = 8,
  localparam int ENT_W = (N_TFLD + 1) * FLD_W,
  localparam int SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FLD_W-1:0] tm_frac,
  input  logic [FLD_W-1:0] tm_sec,
  input  logic [FLD_W-1:0] tm_min,
  input  logic [FLD_W-1:0] tm_hour,
  input  logic [FLD_W-1:0] tm_date,
  input  logic [FLD_W-1:0] tm_month,
  input  logic [FLD_W-1:0] tm_year,
  input  logic             din,
  input  logic             din_rise,
  input  logic             ev_main,
  input  logic             ev_batt,
  input  logic             ev_vlow,
  input  logic             func_en,
  input  logic [EN_W-1:0]  rec_en,
  input  logic             ovw_mode,
  input  logic             bank_clr,
  input  logic [SEL_W-1:0] rd_bank,
  output logic [ENT_W-1:0] rd_stamp
);
  logic [FLG_W-1:0]         flg;
  logic [N_TFLD*FLD_W-1:0]  now_time;

  assign now_time = {tm_year, tm_month, tm_date, tm_hour, tm_min, tm_sec, tm_frac};

  evt_trig_detect u_trig (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .din_rise (din_rise),
    .ev_main  (ev_main),
    .ev_batt  (ev_batt),
    .ev_vlow  (ev_vlow),
    .func_en  (func_en),
    .rec_en   (rec_en),
    .flg      (flg)
  );

  evt_stamp_bank #(
    .NBANK  (NBANK),
    .FLD_W  (FLD_W),
    .FLG_W  (FLG_W),
    .N_TFLD (N_TFLD)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .clr      (bank_clr),
    .ovw      (ovw_mode),
    .cap_flg  (flg),
    .cap_time (now_time),
    .rd_sel   (rd_bank),
    .rd_q     (rd_stamp)
  );

  AST_OFF_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!func_en && !bank_clr) |=> $stable(u_bank.ent)); // R4
endmodule

// File: tb/evt_stamp_rec_bench.sv
module evt_stamp_rec_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tm_frac = '0, tm_sec = '0, tm_min = '0, tm_hour = '0;
  logic [7:0] tm_date = '0, tm_month = '0, tm_year = '0;
  logic       din = 1'b0, din_rise = 1'b1;
  logic       ev_main = 1'b0, ev_batt = 1'b0, ev_vlow = 1'b0;
  logic       func_en = 1'b0, ovw_mode = 1'b0, bank_clr = 1'b0;
  logic [2:0] rec_en = '0;
  logic [1:0] rd_bank = '0;
  logic [63:0] rd_stamp;

  int nchk = 0;
  int nerr = 0;
  logic [63:0] exp_q [4];
  logic [7:0]  tn = 8'h10;
  logic        dl = 1'b0;

  always #5 clk = ~clk;

  evt_stamp_rec u_evt_stamp_rec (
    .clk(clk), .rst(rst),
    .tm_frac(tm_frac), .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
    .tm_date(tm_date), .tm_month(tm_month), .tm_year(tm_year),
    .din(din), .din_rise(din_rise), .ev_main(ev_main), .ev_batt(ev_batt),
    .ev_vlow(ev_vlow), .func_en(func_en), .rec_en(rec_en), .ovw_mode(ovw_mode),
    .bank_clr(bank_clr), .rd_bank(rd_bank), .rd_stamp(rd_stamp)
  );

  task automatic chk(input int b, input string tag);
    rd_bank = b[1:0];
    @(negedge clk);
    nchk++;
    if (rd_stamp !== exp_q[b]) begin
      nerr++;
      $display("FAIL %s slot %0d: actual %h expected %h", tag, b, rd_stamp, exp_q[b]);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int b = 0; b < 4; b++) chk(b, tag);
  endtask

  // drive one event cycle: new din level and pulses {vlow, batt, main}
  task automatic fire(input logic din_nxt, input logic [2:0] pl, input logic clr);
    logic       edg;
    logic [3:0] f;
    edg = din_rise ? (!dl && din_nxt) : (dl && !din_nxt);
    f = {pl[2] & rec_en[2], pl[1] & rec_en[1], pl[0] & rec_en[1], edg & rec_en[0]}
        & {4{func_en}};
    tm_frac = tn; tm_sec = tn + 8'd1; tm_min = tn + 8'd2; tm_hour = tn + 8'd3;
    tm_date = tn + 8'd4; tm_month = tn + 8'd5; tm_year = tn + 8'd6;
    din = din_nxt; ev_main = pl[0]; ev_batt = pl[1]; ev_vlow = pl[2]; bank_clr = clr;
    if (clr) begin
      for (int b = 0; b < 4; b++) exp_q[b] = '0;
    end else if (f != 0 && (ovw_mode || exp_q[3][63:56] == 8'h00)) begin
      for (int b = 3; b > 0; b--) exp_q[b] = exp_q[b-1];
      exp_q[0] = {4'h0, f, tn + 8'd6, tn + 8'd5, tn + 8'd4, tn + 8'd3,
                  tn + 8'd2, tn + 8'd1, tn};
    end
    @(negedge clk);
    ev_main = 1'b0; ev_batt = 1'b0; ev_vlow = 1'b0; bank_clr = 1'b0;
    dl = din_nxt;
    tn = tn + 8'd7;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) exp_q[b] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk_all("R8 reset");

    // freeze mode fill: flags per source, R6 encoding, R5 rising edge
    func_en = 1'b1; rec_en = 3'b111; ovw_mode = 1'b0; din_rise = 1'b1;
    fire(1'b0, 3'b100, 1'b0);
    fire(1'b0, 3'b001, 1'b0);
    fire(1'b0, 3'b010, 1'b0);
    fire(1'b1, 3'b000, 1'b0);
    chk_all("R1 R6 fill");
    fire(1'b1, 3'b100, 1'b0);
    fire(1'b0, 3'b001, 1'b0);
    chk_all("R3 frozen");

    // clear then restart in slot 0
    fire(1'b0, 3'b000, 1'b1);
    chk_all("R7 clear");
    fire(1'b0, 3'b001, 1'b0);
    chk_all("R7 restart");

    // overwrite mode: six captures keep the newest four
    ovw_mode = 1'b1;
    fire(1'b0, 3'b010, 1'b0);
    fire(1'b0, 3'b100, 1'b0);
    fire(1'b0, 3'b011, 1'b0);
    fire(1'b0, 3'b101, 1'b0);
    fire(1'b0, 3'b110, 1'b0);
    chk_all("R2 overwrite");

    // falling polarity
    fire(1'b0, 3'b000, 1'b1);
    din_rise = 1'b0;
    fire(1'b1, 3'b000, 1'b0);
    chk_all("R5 rise ignored");
    fire(1'b0, 3'b000, 1'b0);
    chk_all("R5 fall taken");

    // enables
    func_en = 1'b0;
    fire(1'b0, 3'b111, 1'b0);
    chk_all("R4 global off");
    func_en = 1'b1; rec_en = 3'b011;
    fire(1'b0, 3'b100, 1'b0);
    chk_all("R4 vlow off");
    rec_en = 3'b101;
    fire(1'b0, 3'b011, 1'b0);
    chk_all("R4 supply off");
    rec_en = 3'b111;
    fire(1'b0, 3'b101, 1'b0);
    chk_all("R6 merged");

    // clear beats a simultaneous event
    fire(1'b0, 3'b111, 1'b1);
    chk_all("R7 clear priority");

    // sweep all source masks against all enable masks, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      din_rise = pol[0];
      for (int re = 0; re < 8; re++) begin
        rec_en = re[2:0];
        for (int s = 0; s < 16; s++) begin
          fire(s[0] ? !dl : dl, s[3:1], 1'b0);
          chk(0, "R4 R6 sweep");
        end
        chk(3, "R2 sweep");
      end
    end

    // freeze again after a sweep
    fire(1'b0, 3'b000, 1'b1);
    ovw_mode = 1'b0;
    for (int k = 0; k < 6; k++) fire(dl, 3'b100, 1'b0);
    chk_all("R3 refill");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule